// File: doc/BRIEF.md
# PWM Compare Output Waveform Unit

A 16-bit counter with two compare channels, A and B. Each channel drives one waveform pin and an enable for that pin. A 4-bit waveform-mode input picks one of three counting styles: single-slope fast PWM, dual-slope phase-correct PWM, or a plain non-PWM count. Every style counts up to a shared TOP value. Each channel has a 2-bit action field that decides what a compare match does to its pin: detach the pin, toggle it, clear it or set it. What a match does depends on the counting style and, in dual-slope, on the count direction.

Each channel also has a force strobe. In the non-PWM style the strobe causes an immediate compare match. In the PWM styles the strobe is ignored. The block has no interrupts, no prescaler and no shadow copies of the compare values. The compare inputs act at once.

Top module: `pwm_wave_unit`

## Requirements
- R1: While the synchronous reset is high, the counter is held at 0 counting upward and both waveform levels are 0, so both pins read 0.
- R2: Modes 5, 6, 7 and 15 are fast PWM: the count runs 0..TOP and wraps to 0, a period of TOP+1 cycles. Modes 1, 2, 3, 8, 9, 10, 11 and 14 are dual-slope: the count runs 0..TOP..0, a period of 2*TOP cycles, and turns at TOP and at 0. Modes 0, 4, 12 and 13 are non-PWM: the count runs 0..TOP and wraps.
- R3: Action field 00 drives the channel's enable low and its pin to 0.
- R4: In fast PWM, field 10 sets the level at count 0 and clears it on a match, so the pin is high for CMP of every TOP+1 cycles. Field 11 is the inverse: high for TOP+1-CMP cycles. A match at count 0 takes precedence over the count-0 action.
- R5: In fast PWM, field 01 toggles pin A on each match only in mode 15. Channel B with field 01 is always disabled, and so is channel A in any other fast mode.
- R6: In dual-slope, field 10 clears on a match while counting up and sets on a match while counting down, so the pin is high for 2*CMP of every 2*TOP cycles (0 <= CMP <= TOP). Field 11 is the inverse: high for 2*TOP-2*CMP cycles. The cycle at TOP counts as counting down and the cycle at 0 counts as counting up.
- R7: In dual-slope, field 01 toggles pin A on each match only in modes 9 and 14. Otherwise field 01 disables the channel, and it always disables channel B.
- R8: In fast PWM, when CMP equals TOP and the upper field bit is 1, the match is ignored and only the count-0 action takes place. Field 10 then holds the pin high and field 11 holds it low.
- R9: In non-PWM modes, a match toggles (01), clears (10) or sets (11) the pin on both channels, and nothing happens at count 0.
- R10: In non-PWM modes, a force strobe high for one cycle acts as a match in that cycle. A force and a real match in the same cycle produce one action, not two.
- R11: In PWM modes the force strobes have no effect on either pin.
- R12: A pin changes on the clock edge that ends the cycle in which the count equals its compare value. The enables follow the mode and field inputs without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wgm | input | 4 | Waveform mode (counting style and toggle permission) |
| top_val | input | 16 | Upper count limit TOP |
| cmp_a | input | 16 | Compare value, channel A |
| cmp_b | input | 16 | Compare value, channel B |
| com_a | input | 2 | Match action field, channel A |
| com_b | input | 2 | Match action field, channel B |
| force_a | input | 1 | Force-match strobe, channel A |
| force_b | input | 1 | Force-match strobe, channel B |
| out_a | output | 1 | Waveform pin A |
| out_b | output | 1 | Waveform pin B |
| oe_a | output | 1 | Pin A drive enable |
| oe_b | output | 1 | Pin B drive enable |

## Verification
Two events can fall in the same cycle: a forced match and a real compare match on a channel. The bench raises the toggle channel's strobe during the exact cycle in which the count equals its compare value. It then judges the result by the pin holding a single toggle on the next edge, and by the next natural toggle arriving exactly one period later. A second collision is the count-0 action against a match at count 0 in fast PWM. That case is judged from the duty count: zero for non-inverting and full for inverting.

// File: rtl/pwm_wave_unit.sv
module pwm_wave_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   wgm,
  input  logic [W-1:0] top_val,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [1:0]   com_a,
  input  logic [1:0]   com_b,
  input  logic         force_a,
  input  logic         force_b,
  output logic         out_a,
  output logic         out_b,
  output logic         oe_a,
  output logic         oe_b
);

  logic [W-1:0] cnt;
  logic         dir_up, step_up;
  logic         is_fast, is_dual, is_pwm;
  logic [W-1:0] cmp [2];
  logic [1:0]   com [2];
  logic [1:0]   frc, wave, oe, tog_ok, hit;

  assign is_fast = wgm inside {4'd5, 4'd6, 4'd7, 4'd15};
  assign is_dual = wgm inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11, 4'd14};
  assign is_pwm  = is_fast | is_dual;

  assign step_up = (cnt == '0) ? 1'b1 : (cnt >= top_val) ? 1'b0 : dir_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (is_dual) begin
      dir_up <= step_up;
      if (top_val != '0) cnt <= step_up ? cnt + 1'b1 : cnt - 1'b1;
    end else begin
      dir_up <= 1'b1;
      cnt    <= (cnt >= top_val) ? '0 : cnt + 1'b1;
    end
  end

  assign cmp[0] = cmp_a;
  assign cmp[1] = cmp_b;
  assign com[0] = com_a;
  assign com[1] = com_b;
  assign frc    = {force_b, force_a};

  for (genvar i = 0; i < 2; i++) begin : g_ch
    assign tog_ok[i] = !is_pwm ||
                       ((i == 0) && ((wgm == 4'd15) ||
                                     (is_dual && (wgm == 4'd9 || wgm == 4'd14))));
    assign oe[i]  = com[i][1] || (com[i] == 2'b01 && tog_ok[i]);
    assign hit[i] = ((cnt == cmp[i]) && !(is_fast && com[i][1] && cmp[i] == top_val)) ||
                    (frc[i] && !is_pwm);

    always_ff @(posedge clk) begin
      if (rst) begin
        wave[i] <= 1'b0;
      end else if (oe[i]) begin
        if (hit[i]) begin
          case (com[i])
            2'b01:   wave[i] <= ~wave[i];
            2'b10:   wave[i] <= is_dual ? ~step_up : 1'b0;
            2'b11:   wave[i] <= is_dual ? step_up : 1'b1;
            default: wave[i] <= wave[i];
          endcase
        end else if (is_fast && com[i][1] && cnt == '0) begin
          wave[i] <= ~com[i][0];
        end
      end
    end
  end

  assign out_a = wave[0] & oe[0];
  assign out_b = wave[1] & oe[1];
  assign oe_a  = oe[0];
  assign oe_b  = oe[1];

endmodule

// File: rtl/pwm_wave_unit_chk.sv
module pwm_wave_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   wgm,
  input logic [W-1:0] top_val,
  input logic [W-1:0] cmp_a,
  input logic [1:0]   com_a,
  input logic [1:0]   com_b,
  input logic         force_a,
  input logic         out_a,
  input logic         out_b,
  input logic         oe_a,
  input logic         oe_b
);

  logic fast_m, norm_m;
  assign fast_m = wgm inside {4'd5, 4'd6, 4'd7, 4'd15};
  assign norm_m = wgm inside {4'd0, 4'd4, 4'd12, 4'd13};

  a_r3_detached: assert property (@(posedge clk) disable iff (rst)
    (com_a == 2'b00) |-> (!oe_a && !out_a));

  a_r5_b_never_toggles_fast: assert property (@(posedge clk) disable iff (rst)
    (fast_m && com_b == 2'b01) |-> (!oe_b && !out_b));

  a_r8_top_match_ignored: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fast_m && com_a == 2'b10 && cmp_a == top_val) &&
     fast_m && com_a == 2'b10 && cmp_a == top_val && $past(out_a)) |-> out_a);

  a_r10_single_toggle: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(norm_m && com_a == 2'b01 && force_a) &&
     norm_m && com_a == 2'b01) |-> (out_a != $past(out_a)));

endmodule

bind pwm_wave_unit pwm_wave_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_pwm_wave_unit.sv
module tb_pwm_wave_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic         rst = 1'b1;
  logic [3:0]   wgm = '0;
  logic [W-1:0] top_val = '0, cmp_a = '0, cmp_b = '0;
  logic [1:0]   com_a = '0, com_b = '0;
  logic         force_a = 1'b0, force_b = 1'b0;
  logic         out_a, out_b, oe_a, oe_b;

  pwm_wave_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .wgm(wgm), .top_val(top_val),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .com_a(com_a), .com_b(com_b),
    .force_a(force_a), .force_b(force_b),
    .out_a(out_a), .out_b(out_b), .oe_a(oe_a), .oe_b(oe_b)
  );

  int n_run = 0, n_fail = 0;
  bit mon_done = 1'b0;

  typedef struct {
    string req;
    int    n;
    int    exp_a;
    int    exp_b;
  } item_t;
  item_t sb_q[$];

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(int w, int t, int ca, int cb, int ma, int mb);
    @(negedge clk);
    rst = 1'b1; force_a = 1'b0; force_b = 1'b0;
    wgm = 4'(w); top_val = W'(t); cmp_a = W'(ca); cmp_b = W'(cb);
    com_a = 2'(ma); com_b = 2'(mb);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic duty(string req, int w, int t, int ca, int cb, int ma, int mb,
                      int per, int ea, int eb);
    configure(w, t, ca, cb, ma, mb);
    repeat (2 * per) @(negedge clk);
    mon_done = 1'b0;
    sb_q.push_back('{req, 4 * per, ea, eb});
    wait (mon_done);
  endtask

  initial begin : monitor
    item_t it;
    int ha, hb;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      ha = 0; hb = 0;
      for (int k = 0; k < it.n; k++) begin
        @(negedge clk);
        ha += int'(out_a);
        hb += int'(out_b);
      end
      check({it.req, " out_a high cycles"}, ha, it.exp_a);
      check({it.req, " out_b high cycles"}, hb, it.exp_b);
      mon_done = 1'b1;
    end
  end

  task automatic oe_case(string req, int w, int ma, int mb, int ea, int eb);
    @(negedge clk);
    wgm = 4'(w); com_a = 2'(ma); com_b = 2'(mb);
    #1;
    check({req, " oe_a"}, int'(oe_a), ea);
    check({req, " oe_b"}, int'(oe_b), eb);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin : driver
    int lows;
    // R1 reset state
    configure(5, 10, 4, 3, 2, 3);
    rst = 1'b1;
    @(negedge clk);
    check("R1 out_a in reset", int'(out_a), 0);
    check("R1 out_b in reset", int'(out_b), 0);
    check("R1 oe_a in reset", int'(oe_a), 1);

    // R3 R5 R7 R9 enables
    oe_case("R3 detached", 5, 0, 0, 0, 0);
    oe_case("R5 fast mode5 field01", 5, 1, 2, 0, 1);
    oe_case("R5 fast mode15 field01", 15, 1, 1, 1, 0);
    oe_case("R7 dual mode9 field01", 9, 1, 1, 1, 0);
    oe_case("R7 dual mode14 field01", 14, 1, 1, 1, 0);
    oe_case("R7 dual mode2 field01", 2, 1, 3, 0, 1);
    oe_case("R9 normal field01", 0, 1, 1, 1, 1);

    // fast PWM, TOP=10, period 11
    duty("R4 R2 fast noninv/inv", 5, 10, 4, 3, 2, 3, 11, 16, 32);
    duty("R4 fast cmp zero", 6, 10, 0, 0, 2, 3, 11, 0, 44);
    duty("R8 fast cmp equals TOP", 7, 10, 10, 10, 2, 3, 11, 44, 0);
    duty("R5 fast toggle mode15", 15, 10, 5, 5, 1, 1, 22, 44, 0);
    duty("R5 fast field01 mode5", 5, 10, 5, 5, 1, 1, 22, 0, 0);
    // dual slope, TOP=10, period 20
    duty("R6 R2 dual noninv/inv", 1, 10, 3, 8, 2, 3, 20, 24, 16);
    duty("R6 dual cmp TOP and zero", 3, 10, 10, 0, 2, 2, 20, 80, 0);
    duty("R7 dual toggle mode9", 9, 10, 3, 3, 1, 1, 20, 56, 0);
    duty("R7 dual toggle mode14", 14, 10, 6, 6, 1, 1, 20, 32, 0);
    duty("R7 dual field01 mode1", 1, 10, 3, 3, 1, 1, 20, 0, 0);
    // normal, TOP=10, toggle period 22
    duty("R9 R2 normal toggle both", 0, 10, 2, 9, 1, 1, 22, 44, 44);
    duty("R3 normal detached A", 4, 10, 2, 9, 0, 1, 22, 0, 44);

    // R9 R12 set then clear in normal mode, TOP=9
    configure(0, 9, 2, 300, 3, 0);
    repeat (2) @(negedge clk);
    check("R12 out_a before match edge", int'(out_a), 0);
    @(negedge clk);
    check("R9 R12 out_a set on match", int'(out_a), 1);
    com_a = 2'b10;
    repeat (9) @(negedge clk);
    check("R9 out_a held before clear", int'(out_a), 1);
    @(negedge clk);
    check("R9 out_a clear on match", int'(out_a), 0);

    // R10 force in normal mode, coincident with a real match on B
    configure(0, 9, 1000, 4, 3, 1);
    repeat (4) @(negedge clk);
    check("R10 out_a before force", int'(out_a), 0);
    check("R12 out_b before match", int'(out_b), 0);
    force_a = 1'b1; force_b = 1'b1;
    @(negedge clk);
    force_a = 1'b0; force_b = 1'b0;
    check("R10 out_a forced set", int'(out_a), 1);
    check("R10 out_b single toggle", int'(out_b), 1);
    repeat (9) @(negedge clk);
    check("R10 out_b no early toggle", int'(out_b), 1);
    @(negedge clk);
    check("R10 out_b next period toggle", int'(out_b), 0);
    check("R10 out_a holds", int'(out_a), 1);

    // R11 force ignored in fast and dual modes
    configure(7, 10, 10, 0, 2, 0);
    repeat (22) @(negedge clk);
    lows = 0;
    force_a = 1'b1;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      lows += int'(!out_a);
    end
    force_a = 1'b0;
    check("R11 fast force leaves out_a high (low cycles)", lows, 0);

    configure(1, 10, 0, 1000, 0, 3);
    repeat (5) @(negedge clk);
    lows = 0;
    force_b = 1'b1;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      lows += int'(out_b);
    end
    force_b = 1'b0;
    check("R11 dual force leaves out_b low (high cycles)", lows, 0);

    finish_run();
  end
endmodule